// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register File

This block is the host-facing register file of an Ethernet DMA engine. A simple 32-bit bus presents byte addresses; the block turns each one into a word index by dropping the two low address bits and decodes that index into the registers that steer the descriptor engines. These are the bus-mode word, the receive and transmit descriptor-list bases, the matching current-descriptor pointers, the control word, the interrupt-enable mask and the event status word. The descriptor engines, the MAC datapath and the address filters sit outside. They reach this block only through a 32-bit status-set vector and through the control outputs it drives.

Status bits are raised by the engines and cleared by the host with write-one-to-clear. If an engine raises a bit in the same cycle as the host clears it, the raise wins. A single level interrupt is high while any enabled status bit is set. A write to the transmit poll-demand word stores nothing and produces a one-cycle kick toward the transmit engine. Writing a list base also rewinds the current-descriptor pointer for that direction. Other in-range indices act as plain storage. The version word returns a fixed code.

Top module: `dmaRegFile`

## Requirements
- R1: The word index is the byte address shifted right by two; the two low address bits are ignored. Named words sit at these indices: 0x008 version, 0x3C0 bus mode, 0x3C1 transmit poll demand, 0x3C3 receive list base, 0x3C4 transmit list base, 0x3C5 status, 0x3C6 control, 0x3C7 interrupt enable, 0x3D2 current transmit descriptor, 0x3D3 current receive descriptor.
- R2: Any other index below REG_SPACE (default 1024) reads back the last value written to it. An index at or above REG_SPACE reads 0, and a write to it has no effect.
- R3: A read of index 0x008 always returns VERSION_CODE (default 0x00001012), and writes there are dropped.
- R4: A write to bus mode stores the written value with bit 0 cleared. The stored value appears on busMode and on reads.
- R5: A write to index 0x3C1 makes txPollDemand high for exactly the one cycle after the write edge. That index stores nothing and reads 0.
- R6: A write to status clears each status bit whose written bit is 1 and keeps each bit written 0. No status bit rises without a request.
- R7: A 1 on stsSetIn[b] sets status bit b at the next edge, even when a write-one-to-clear of that bit happens in the same cycle.
- R8: irq is high exactly when (status AND interrupt enable) is nonzero, following each register update with no further delay.
- R9: Writing the receive list base loads the same value into the current receive descriptor. Writing the transmit list base does the same for the current transmit descriptor. Each current pointer can also be written directly.
- R10: rxRunEn follows control bit 1 and txRunEn follows control bit 13.
- R11: A read request returns its data on rdData in the cycle after the request edge, and rdData holds until the next read. After reset all named registers, outputs and rdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busAddr | input | BYTE_ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after the request |
| stsSetIn | input | 32 | Status-set requests from the engines |
| dmaStatus | output | 32 | Current status word |
| irq | output | 1 | Level interrupt |
| txPollDemand | output | 1 | One-cycle transmit kick |
| busMode | output | 32 | Bus-mode word |
| rxBase | output | 32 | Receive list base |
| txBase | output | 32 | Transmit list base |
| curRxDesc | output | 32 | Current receive descriptor pointer |
| curTxDesc | output | 32 | Current transmit descriptor pointer |
| rxRunEn | output | 1 | Receive engine run enable |
| txRunEn | output | 1 | Transmit engine run enable |

## Verification
The bench builds the block with its defaults: a 13-bit byte address and a REG_SPACE of 1024. With those values the whole 2048-entry index space can be written and read back in one sweep, so the in-range storage, the out-of-range half and every named index are all covered. The 32-bit status word keeps the sweeps over every status bit short. Every clear position, every set-versus-clear collision and all 1024 pairs of enable bit and status bit can be tried.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;

  localparam int unsigned IDX_VERSION = 32'h008;
  localparam int unsigned IDX_BUSMODE = 32'h3C0;
  localparam int unsigned IDX_TXPOLL  = 32'h3C1;
  localparam int unsigned IDX_RXBASE  = 32'h3C3;
  localparam int unsigned IDX_TXBASE  = 32'h3C4;
  localparam int unsigned IDX_STATUS  = 32'h3C5;
  localparam int unsigned IDX_CTRL    = 32'h3C6;
  localparam int unsigned IDX_IEN     = 32'h3C7;
  localparam int unsigned IDX_CURTX   = 32'h3D2;
  localparam int unsigned IDX_CURRX   = 32'h3D3;

  localparam int unsigned RX_RUN_BIT = 1;
  localparam int unsigned TX_RUN_BIT = 13;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_VERSION,
    SEL_BUSMODE,
    SEL_RXBASE,
    SEL_TXBASE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_IEN,
    SEL_CURTX,
    SEL_CURRX,
    SEL_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic   wrBusMode;
    logic   wrRxBase;
    logic   wrTxBase;
    logic   wrStatus;
    logic   wrCtrl;
    logic   wrIen;
    logic   wrCurTx;
    logic   wrCurRx;
    logic   wrScratch;
    logic   txKick;
    logic   rd;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int unsigned BYTE_ADDR_W = 13,
  parameter int unsigned REG_SPACE   = 1024,
  localparam int unsigned IDX_W      = BYTE_ADDR_W - 2,
  localparam int unsigned SPACE_W    = $clog2(REG_SPACE)
) (
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [BYTE_ADDR_W-1:0] busAddr,
  output regStrobe_t             strb,
  output logic [SPACE_W-1:0]     scratchIdx
);

  logic [IDX_W-1:0] wordIdx;
  logic [31:0]      idxWide;
  logic             inSpace;
  logic             unusedLowBits;
  rdSel_e           sel;

  assign wordIdx       = busAddr[BYTE_ADDR_W-1:2];
  assign unusedLowBits = ^busAddr[1:0];
  assign idxWide       = 32'(wordIdx);
  assign inSpace       = idxWide < REG_SPACE;
  assign scratchIdx    = wordIdx[SPACE_W-1:0];

  // Classify the index once; write strobes and read select both derive from it.
  always_comb begin
    if (!inSpace) begin
      sel = SEL_ZERO;
    end else begin
      unique case (idxWide)
        IDX_VERSION: sel = SEL_VERSION;
        IDX_BUSMODE: sel = SEL_BUSMODE;
        IDX_TXPOLL:  sel = SEL_ZERO;
        IDX_RXBASE:  sel = SEL_RXBASE;
        IDX_TXBASE:  sel = SEL_TXBASE;
        IDX_STATUS:  sel = SEL_STATUS;
        IDX_CTRL:    sel = SEL_CTRL;
        IDX_IEN:     sel = SEL_IEN;
        IDX_CURTX:   sel = SEL_CURTX;
        IDX_CURRX:   sel = SEL_CURRX;
        default:     sel = SEL_SCRATCH;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.rdSel     = sel;
    strb.rd        = busRdEn;
    strb.wrBusMode = busWrEn && (sel == SEL_BUSMODE);
    strb.wrRxBase  = busWrEn && (sel == SEL_RXBASE);
    strb.wrTxBase  = busWrEn && (sel == SEL_TXBASE);
    strb.wrStatus  = busWrEn && (sel == SEL_STATUS);
    strb.wrCtrl    = busWrEn && (sel == SEL_CTRL);
    strb.wrIen     = busWrEn && (sel == SEL_IEN);
    strb.wrCurTx   = busWrEn && (sel == SEL_CURTX);
    strb.wrCurRx   = busWrEn && (sel == SEL_CURRX);
    strb.wrScratch = busWrEn && (sel == SEL_SCRATCH);
    strb.txKick    = busWrEn && inSpace && (idxWide == IDX_TXPOLL);
  end

endmodule

// File: rtl/dmaRegDatapath.sv
module dmaRegDatapath
  import dmaRegPkg::*;
#(
  parameter int unsigned  REG_SPACE    = 1024,
  parameter logic [31:0]  VERSION_CODE = 32'h0000_1012,
  localparam int unsigned SPACE_W      = $clog2(REG_SPACE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [SPACE_W-1:0] scratchIdx,
  input  logic [31:0]        wrData,
  input  logic [31:0]        stsSetIn,
  output logic [31:0]        rdData,
  output logic [31:0]        statusQ,
  output logic [31:0]        ienQ,
  output logic [31:0]        ctrlQ,
  output logic [31:0]        busModeQ,
  output logic [31:0]        rxBaseQ,
  output logic [31:0]        txBaseQ,
  output logic [31:0]        curRxQ,
  output logic [31:0]        curTxQ,
  output logic               txKickQ
);

  logic [31:0] scratchMem [REG_SPACE];
  logic [31:0] memQ;
  logic [31:0] namedQ;
  logic [31:0] namedMux;
  logic [31:0] statusNext;
  rdSel_e      rdSelQ;

  // Per-bit merge: an engine request beats a host clear in the same cycle.
  for (genvar b = 0; b < 32; b++) begin : g_stsBit
    assign statusNext[b] = stsSetIn[b] | (statusQ[b] & ~(strb.wrStatus & wrData[b]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      ienQ     <= '0;
      ctrlQ    <= '0;
      busModeQ <= '0;
      rxBaseQ  <= '0;
      txBaseQ  <= '0;
      curRxQ   <= '0;
      curTxQ   <= '0;
      txKickQ  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      txKickQ <= strb.txKick;
      if (strb.wrIen)     ienQ     <= wrData;
      if (strb.wrCtrl)    ctrlQ    <= wrData;
      if (strb.wrBusMode) busModeQ <= {wrData[31:1], 1'b0};
      if (strb.wrRxBase)  rxBaseQ  <= wrData;
      if (strb.wrTxBase)  txBaseQ  <= wrData;
      if (strb.wrRxBase || strb.wrCurRx) curRxQ <= wrData;
      if (strb.wrTxBase || strb.wrCurTx) curTxQ <= wrData;
    end
  end

  // Plain storage words: no reset, single port, read-before-write.
  always_ff @(posedge clk) begin
    if (strb.wrScratch) scratchMem[scratchIdx] <= wrData;
    if (strb.rd)        memQ <= scratchMem[scratchIdx];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_VERSION: namedMux = VERSION_CODE;
      SEL_BUSMODE: namedMux = busModeQ;
      SEL_RXBASE:  namedMux = rxBaseQ;
      SEL_TXBASE:  namedMux = txBaseQ;
      SEL_STATUS:  namedMux = statusQ;
      SEL_CTRL:    namedMux = ctrlQ;
      SEL_IEN:     namedMux = ienQ;
      SEL_CURTX:   namedMux = curTxQ;
      SEL_CURRX:   namedMux = curRxQ;
      default:     namedMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      namedQ <= '0;
      rdSelQ <= SEL_ZERO;
    end else if (strb.rd) begin
      namedQ <= namedMux;
      rdSelQ <= strb.rdSel;
    end
  end

  assign rdData = (rdSelQ == SEL_SCRATCH) ? memQ : namedQ;

endmodule

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaRegPkg::*;
#(
  parameter int unsigned BYTE_ADDR_W  = 13,
  parameter int unsigned REG_SPACE    = 1024,
  parameter logic [31:0] VERSION_CODE = 32'h0000_1012
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [BYTE_ADDR_W-1:0] busAddr,
  input  logic [31:0]            busWrData,
  output logic [31:0]            rdData,
  input  logic [31:0]            stsSetIn,
  output logic [31:0]            dmaStatus,
  output logic                   irq,
  output logic                   txPollDemand,
  output logic [31:0]            busMode,
  output logic [31:0]            rxBase,
  output logic [31:0]            txBase,
  output logic [31:0]            curRxDesc,
  output logic [31:0]            curTxDesc,
  output logic                   rxRunEn,
  output logic                   txRunEn
);

  localparam int unsigned SPACE_W = $clog2(REG_SPACE);

  regStrobe_t         strb;
  logic [SPACE_W-1:0] scratchIdx;
  logic [31:0]        ienQ;
  logic [31:0]        ctrlQ;

  dmaRegCtrl #(
    .BYTE_ADDR_W(BYTE_ADDR_W),
    .REG_SPACE  (REG_SPACE)
  ) u_ctrl (
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .strb      (strb),
    .scratchIdx(scratchIdx)
  );

  dmaRegDatapath #(
    .REG_SPACE   (REG_SPACE),
    .VERSION_CODE(VERSION_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .scratchIdx(scratchIdx),
    .wrData    (busWrData),
    .stsSetIn  (stsSetIn),
    .rdData    (rdData),
    .statusQ   (dmaStatus),
    .ienQ      (ienQ),
    .ctrlQ     (ctrlQ),
    .busModeQ  (busMode),
    .rxBaseQ   (rxBase),
    .txBaseQ   (txBase),
    .curRxQ    (curRxDesc),
    .curTxQ    (curTxDesc),
    .txKickQ   (txPollDemand)
  );

  assign irq     = |(dmaStatus & ienQ);
  assign rxRunEn = ctrlQ[RX_RUN_BIT];
  assign txRunEn = ctrlQ[TX_RUN_BIT];

endmodule

// File: rtl/dmaRegFileChecker.sv
module dmaRegFileChecker #(
  parameter int unsigned BYTE_ADDR_W = 13
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWrEn,
  input logic [BYTE_ADDR_W-1:0] busAddr,
  input logic [31:0]            busWrData,
  input logic [31:0]            stsSetIn,
  input logic [31:0]            dmaStatus,
  input logic                   irq,
  input logic                   txPollDemand,
  input logic [31:0]            busMode,
  input logic [31:0]            rxBase,
  input logic [31:0]            txBase,
  input logic [31:0]            curRxDesc,
  input logic [31:0]            curTxDesc
);

  logic [31:0] wIdx;
  logic        wrPoll, wrSts, wrBm, wrRxB, wrTxB;

  assign wIdx   = 32'(busAddr >> 2);
  assign wrPoll = busWrEn && (wIdx == 32'h3C1);
  assign wrSts  = busWrEn && (wIdx == 32'h3C5);
  assign wrBm   = busWrEn && (wIdx == 32'h3C0);
  assign wrRxB  = busWrEn && (wIdx == 32'h3C3);
  assign wrTxB  = busWrEn && (wIdx == 32'h3C4);

  assert_kick_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    txPollDemand |-> $past(wrPoll));

  assert_kick_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrPoll)) |-> txPollDemand);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrSts)) |->
      ((dmaStatus & $past(busWrData) & ~$past(stsSetIn)) == 32'h0));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((dmaStatus & ~$past(dmaStatus) & ~$past(stsSetIn)) == 32'h0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((dmaStatus & $past(stsSetIn)) == $past(stsSetIn)));

  assert_busmode_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrBm)) |-> (busMode == {$past(busWrData[31:1]), 1'b0}));

  assert_rx_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrRxB)) |-> (curRxDesc == $past(busWrData) && rxBase == $past(busWrData)));

  assert_tx_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrTxB)) |-> (curTxDesc == $past(busWrData) && txBase == $past(busWrData)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaStatus == 32'h0) |-> !irq);

endmodule

bind dmaRegFile dmaRegFileChecker #(.BYTE_ADDR_W(BYTE_ADDR_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .stsSetIn    (stsSetIn),
  .dmaStatus   (dmaStatus),
  .irq         (irq),
  .txPollDemand(txPollDemand),
  .busMode     (busMode),
  .rxBase      (rxBase),
  .txBase      (txBase),
  .curRxDesc   (curRxDesc),
  .curTxDesc   (curTxDesc)
);

// File: tb/dmaRegFile_bench.sv
module dmaRegFile_bench;

  localparam int unsigned BA_W  = 13;
  localparam int unsigned SPACE = 1024;
  localparam int unsigned NIDX  = 1 << (BA_W - 2);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busWrEn = 1'b0;
  logic            busRdEn = 1'b0;
  logic [BA_W-1:0] busAddr = '0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     stsSetIn = '0;
  logic [31:0]     rdData, dmaStatus, busMode, rxBase, txBase, curRxDesc, curTxDesc;
  logic            irq, txPollDemand, rxRunEn, txRunEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dmaRegFile u_dmaRegFile (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .rdData(rdData), .stsSetIn(stsSetIn), .dmaStatus(dmaStatus),
    .irq(irq), .txPollDemand(txPollDemand), .busMode(busMode), .rxBase(rxBase),
    .txBase(txBase), .curRxDesc(curRxDesc), .curTxDesc(curTxDesc),
    .rxRunEn(rxRunEn), .txRunEn(txRunEn)
  );

  function automatic logic [31:0] pat(int unsigned i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [BA_W-1:0] addrOf(int unsigned idx);
    return BA_W'((idx << 2) | (idx & 3));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // One bus cycle: drive at a falling edge, release at the next falling edge.
  task automatic cyc(bit wr, bit rd, int unsigned idx, logic [31:0] data, logic [31:0] set);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = addrOf(idx); busWrData = data; stsSetIn = set;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0; stsSetIn = '0;
  endtask

  task automatic wr(int unsigned idx, logic [31:0] data);
    cyc(1'b1, 1'b0, idx, data, 32'h0);
  endtask

  task automatic rd(int unsigned idx, output logic [31:0] v);
    cyc(1'b0, 1'b1, idx, 32'h0, 32'h0);
    v = rdData;
  endtask

  function automatic logic [31:0] sweepExp(int unsigned i);
    if (i >= SPACE)  return 32'h0;
    if (i == 32'h008) return 32'h0000_1012;
    if (i == 32'h3C0) return pat(i) & ~32'h1;
    if (i == 32'h3C1) return 32'h0;
    if (i == 32'h3C5) return 32'h0;
    return pat(i);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 reset status", dmaStatus, 32'h0);
    check("R11 reset irq", {31'h0, irq}, 32'h0);
    check("R11 reset kick", {31'h0, txPollDemand}, 32'h0);
    check("R11 reset busMode", busMode, 32'h0);
    check("R11 reset curRx", curRxDesc, 32'h0);
    check("R11 reset rdData", rdData, 32'h0);

    // R5 kick width and stored nothing
    wr(32'h3C1, 32'hFFFF_FFFF);
    check("R5 kick high", {31'h0, txPollDemand}, 32'h1);
    @(negedge clk);
    check("R5 kick one cycle", {31'h0, txPollDemand}, 32'h0);
    wr(32'h3C2, 32'h1234_5678);
    check("R5 no kick from other index", {31'h0, txPollDemand}, 32'h0);

    // R1 R2 R3 R4 full index sweep: write all, then read all
    for (int unsigned i = 0; i < NIDX; i++) wr(i, pat(i));
    for (int unsigned i = 0; i < NIDX; i++) begin
      rd(i, v);
      check($sformatf("R1 R2 sweep idx %h", i), v, sweepExp(i));
    end
    check("R4 busMode port", busMode, pat(32'h3C0) & ~32'h1);
    check("R9 curRx direct", curRxDesc, pat(32'h3D3));
    check("R10 rxRunEn", {31'h0, rxRunEn}, {31'h0, pat(32'h3C6)[1]});
    check("R10 txRunEn", {31'h0, txRunEn}, {31'h0, pat(32'h3C6)[13]});
    check("R8 irq with zero status", {31'h0, irq}, 32'h0);

    // R3 write ignored, R2 out-of-range write ignored
    wr(32'h008, 32'hDEAD_BEEF);
    rd(32'h008, v);
    check("R3 version fixed", v, 32'h0000_1012);
    wr(32'h500, 32'hCAFE_F00D);
    rd(32'h500, v);
    check("R2 out of range", v, 32'h0);
    wr(32'h3C0, 32'h0000_00FF);
    check("R4 bit0 cleared", busMode, 32'h0000_00FE);

    // R10 control bits
    wr(32'h3C6, 32'h0000_0002);
    check("R10 rx only", {30'h0, txRunEn, rxRunEn}, 32'h1);
    wr(32'h3C6, 32'h0000_2000);
    check("R10 tx only", {30'h0, txRunEn, rxRunEn}, 32'h2);

    // R9 base reload
    wr(32'h3D3, 32'h1111_0000);
    wr(32'h3C3, 32'hA000_0040);
    check("R9 rx reload", curRxDesc, 32'hA000_0040);
    rd(32'h3D3, v);
    check("R9 rx reload read", v, 32'hA000_0040);
    wr(32'h3D2, 32'h2222_0000);
    wr(32'h3C4, 32'hB000_0080);
    check("R9 tx reload", curTxDesc, 32'hB000_0080);
    check("R9 rx untouched by tx base", curRxDesc, 32'hA000_0040);

    // R6 clear each bit, R7 collision per bit
    wr(32'h3C7, 32'h0);
    for (int b = 0; b < 32; b++) begin
      cyc(1'b0, 1'b0, 0, 32'h0, 32'hFFFF_FFFF);
      check($sformatf("R7 set all b%0d", b), dmaStatus, 32'hFFFF_FFFF);
      wr(32'h3C5, 32'h1 << b);
      check($sformatf("R6 clear b%0d", b), dmaStatus, ~(32'h1 << b));
      cyc(1'b1, 1'b0, 32'h3C5, 32'hFFFF_FFFF, 32'h1 << b);
      check($sformatf("R7 collision b%0d", b), dmaStatus, 32'h1 << b);
      wr(32'h3C5, 32'hFFFF_FFFF);
      check($sformatf("R6 clear all b%0d", b), dmaStatus, 32'h0);
    end

    // R8 every enable bit against every status bit
    for (int e = 0; e < 32; e++) begin
      wr(32'h3C7, 32'h1 << e);
      for (int s = 0; s < 32; s++) begin
        cyc(1'b0, 1'b0, 0, 32'h0, 32'h1 << s);
        check($sformatf("R8 irq en%0d st%0d", e, s), {31'h0, irq}, {31'h0, e == s});
        wr(32'h3C5, 32'h1 << s);
        check($sformatf("R8 irq drop en%0d st%0d", e, s), {31'h0, irq}, 32'h0);
      end
    end

    // R11 rdData holds between reads
    rd(32'h3C4, v);
    repeat (3) @(negedge clk);
    check("R11 rdData hold", rdData, 32'hB000_0080);

    finishRun();
  end

endmodule